// File: doc/BRIEF.md
# Event Counter Bank with Global Control

The block holds eight event counters. Each one sits in a 64-bit register: a 32-bit count in the low half and a 32-bit control word in the high half. Each counter has its own event input line. A one-cycle pulse on that line advances the counter by one unless the counter is frozen. One bit of the control word selects saturation. With saturation on, a counter that has reached all-ones stays there. With it off, the counter wraps to zero and records an overflow.

A ninth register gives global control. A single write to it carries an eight-bit select mask and up to three command pulses: freeze, unfreeze and clear. The commands act on every selected counter at once. The same register reads back the select mask and one overflow status bit per counter. All nine registers sit behind a plain address/write-enable/data port with a combinational read path.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset every count, control word, select mask and status bit is zero, and every counter is counting (not frozen).
- R2: Addresses 0 to 7 select counter 0 to 7. Data bits 31:0 are the count and bits 63:32 the control word. A write loads both halves and a read returns them.
- R3: An unfrozen counter adds one for each clock cycle its event input is high. A direct write in the same cycle as an event takes priority over the increment.
- R4: A counter with saturation off wraps from FFFF_FFFFh to zero on the next event. In the same cycle it sets its overflow status bit, which is bit 48+n of the global register.
- R5: Register bit 59 (control bit 27) enables saturation. A saturating counter stops at FFFF_FFFFh and never sets its status bit.
- R6: A write to address 8 with bit 0 set freezes every counter n whose select bit 16+n is set in that write. A frozen counter ignores events from the next cycle on. Unselected counters keep counting.
- R7: A write to address 8 with bit 1 set unfreezes the counters selected in that write.
- R8: A write to address 8 with bit 2 set clears the count and the status bit of each selected counter. It leaves the control words unchanged and does not affect unselected counters.
- R9: If freeze and unfreeze arrive in the same write, freeze wins. A clear in that same write is applied as well.
- R10: Address 8 reads the stored select mask in bits 23:16 and the status bits in 55:48. Bits 2:0 always read zero. Writes to the status bits have no effect, and a command with an empty select mask changes nothing.
- R11: A direct write to a counter register clears that counter's status bit.
- R12: A frozen counter can still be written and read through the port.
- R13: Addresses 9 to 15 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for addr_i (combinational) |
| event_i | input | 8 | One event line per counter |

## Verification
A wrong freeze flag shows as a count that moves, or stays still, under event pulses. This is visible on the first read after the pulses. A lost or stuck overflow bit shows on the next read of address 8, either right after a wrap or right after a clearing write. Command bits that fail to clear themselves, or a clear that reaches an unselected counter, appear as a changed count on another address one cycle after the global write.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned REG_W   = 64;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned CTL_W   = 32;
  localparam int unsigned SAT_BIT = 27;  // bit 59 of the counter register
  localparam int unsigned CMD_FRZ   = 0;
  localparam int unsigned CMD_UNFRZ = 1;
  localparam int unsigned CMD_CLR   = 2;
  localparam int unsigned SEL_LSB   = 16;
  localparam int unsigned STS_LSB   = 48;
endpackage

// File: rtl/evt_glb_ctl.sv
module evt_glb_ctl #(
  parameter int unsigned NUM_CTR = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [2:0]         cmd_i,
  input  logic [NUM_CTR-1:0] sel_i,
  output logic [NUM_CTR-1:0] sel_o,
  output logic [NUM_CTR-1:0] frz_o,
  output logic [NUM_CTR-1:0] unfrz_o,
  output logic [NUM_CTR-1:0] clr_o
);
  import evt_pkg::*;

  logic [NUM_CTR-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= '0;
    else if (wr_i) sel_q <= sel_i;
  end

  // commands use the mask carried by the same write
  always_comb begin
    frz_o   = (wr_i && cmd_i[CMD_FRZ])   ? sel_i : '0;
    unfrz_o = (wr_i && cmd_i[CMD_UNFRZ]) ? sel_i : '0;
    clr_o   = (wr_i && cmd_i[CMD_CLR])   ? sel_i : '0;
  end

  assign sel_o = sel_q;

  a_r10_sel_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> sel_o == $past(sel_i));
endmodule

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice
  import evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             frz_i,
  input  logic             unfrz_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             ovf_o,
  output logic             frozen_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q, count_d;
  logic [CTL_W-1:0] ctl_q;
  logic             ovf_q, ovf_d, frozen_q, sat, at_max, step;

  assign sat    = ctl_q[SAT_BIT];
  assign at_max = (count_q == CNT_MAX);
  assign step   = event_i && !frozen_q;

  always_comb begin
    count_d = count_q;
    ovf_d   = ovf_q;
    if (wr_i) begin
      count_d = wdata_i[CNT_W-1:0];
      ovf_d   = 1'b0;
    end else if (clr_i) begin
      count_d = '0;
      ovf_d   = 1'b0;
    end else if (step) begin
      if (sat && at_max) count_d = CNT_MAX;
      else               count_d = count_q + 1'b1;
      if (!sat && at_max) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      ctl_q    <= '0;
      ovf_q    <= 1'b0;
      frozen_q <= 1'b0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
      if (wr_i)         ctl_q    <= wdata_i[REG_W-1:CNT_W];
      if (frz_i)        frozen_q <= 1'b1;  // freeze wins over unfreeze
      else if (unfrz_i) frozen_q <= 1'b0;
    end
  end

  assign count_o  = count_q;
  assign ctl_o    = ctl_q;
  assign ovf_o    = ovf_q;
  assign frozen_o = frozen_q;

  a_r6_frozen_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && !wr_i && !clr_i) |=> count_q == $past(count_q));
  a_r4_wrap_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && !frozen_q && !sat && at_max && !wr_i && !clr_i) |=> (ovf_q && count_q == '0));
  a_r5_sat_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && sat && at_max && !wr_i && !clr_i) |=> (at_max && $stable(ovf_q)));
  a_r8_clr_keeps_ctl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_i) |=> (count_q == '0 && !ovf_q && $stable(ctl_q)));
  a_r11_wr_clears_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !ovf_q);
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank #(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [evt_pkg::REG_W-1:0] wdata_i,
  output logic [evt_pkg::REG_W-1:0] rdata_o,
  input  logic [NUM_CTR-1:0]        event_i
);
  import evt_pkg::*;

  localparam logic [ADDR_W-1:0] GLB_ADDR = ADDR_W'(NUM_CTR);

  logic               glb_wr;
  logic [NUM_CTR-1:0] ctr_wr, sel, frz, unfrz, clr, ovf, frozen;
  logic [NUM_CTR-1:0][CNT_W-1:0] count;
  logic [NUM_CTR-1:0][CTL_W-1:0] ctl;

  assign glb_wr = wr_en_i && (addr_i == GLB_ADDR);

  evt_glb_ctl #(.NUM_CTR(NUM_CTR)) i_glb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (glb_wr),
    .cmd_i   (wdata_i[2:0]),
    .sel_i   (wdata_i[SEL_LSB +: NUM_CTR]),
    .sel_o   (sel),
    .frz_o   (frz),
    .unfrz_o (unfrz),
    .clr_o   (clr)
  );

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    assign ctr_wr[n] = wr_en_i && (addr_i == ADDR_W'(n));

    evt_ctr_slice i_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .event_i  (event_i[n]),
      .wr_i     (ctr_wr[n]),
      .wdata_i  (wdata_i),
      .frz_i    (frz[n]),
      .unfrz_i  (unfrz[n]),
      .clr_i    (clr[n]),
      .count_o  (count[n]),
      .ctl_o    (ctl[n]),
      .ovf_o    (ovf[n]),
      .frozen_o (frozen[n])
    );

    a_r9_freeze_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (glb_wr && wdata_i[CMD_FRZ] && wdata_i[SEL_LSB+n]) |=> frozen[n]);
    a_r7_unfreeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (glb_wr && wdata_i[CMD_UNFRZ] && !wdata_i[CMD_FRZ] && wdata_i[SEL_LSB+n]) |=> !frozen[n]);
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (addr_i == ADDR_W'(n)) rdata_o = {ctl[n], count[n]};
    end
    if (addr_i == GLB_ADDR) begin
      rdata_o[SEL_LSB +: NUM_CTR] = sel;
      rdata_o[STS_LSB +: NUM_CTR] = ovf;
    end
  end

  a_r10_cmd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == GLB_ADDR) |-> rdata_o[2:0] == 3'b000);
endmodule

// File: tb/test_evt_ctr_bank.sv
module test_evt_ctr_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic [7:0]  event_i = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  evt_ctr_bank i_evt_ctr_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .event_i(event_i)
  );

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m, input int n);
    @(negedge clk_i); event_i = m;
    repeat (n) @(negedge clk_i);
    event_i = '0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk_i); addr_i = a; #1;
    checks++;
    if (rdata_o !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, rdata_o, exp);
    end
  endtask

  task automatic t_reset;
    for (int a = 0; a < 9; a++) rd_chk(4'(a), 64'h0, "R1 reset value");
    pulse(8'h01, 1);
    rd_chk(0, 64'h1, "R1 counting after reset");
  endtask

  task automatic t_rw;
    wr(3, 64'h0000_5A5A_0000_00AB);
    rd_chk(3, 64'h0000_5A5A_0000_00AB, "R2 readback");
  endtask

  task automatic t_count;
    wr(1, 64'h0);
    pulse(8'h02, 5);
    rd_chk(1, 64'h5, "R3 five events");
    @(negedge clk_i); addr_i = 2; wdata_i = 64'd100; wr_en_i = 1'b1; event_i = 8'h04;
    @(negedge clk_i); wr_en_i = 1'b0; event_i = '0;
    rd_chk(2, 64'd100, "R3 write beats event");
  endtask

  task automatic t_wrap;
    wr(4, 64'h0000_0000_FFFF_FFFF);
    pulse(8'h10, 1);
    rd_chk(4, 64'h0, "R4 wrap to zero");
    rd_chk(8, 64'h0010_0000_0000_0000, "R4 status bit 52");
    pulse(8'h10, 1);
    rd_chk(8, 64'h0010_0000_0000_0000, "R4 status sticky");
    wr(4, 64'h9);
    rd_chk(8, 64'h0, "R11 write clears status");
    rd_chk(4, 64'h9, "R11 written value");
  endtask

  task automatic t_sat;
    wr(5, 64'h0800_0000_FFFF_FFFE);
    pulse(8'h20, 3);
    rd_chk(5, 64'h0800_0000_FFFF_FFFF, "R5 pinned at max");
    rd_chk(8, 64'h0, "R5 no status");
  endtask

  task automatic t_freeze;
    wr(0, 64'h0); wr(1, 64'h0); wr(2, 64'h0);
    wr(8, 64'h0000_0000_0003_0001);
    pulse(8'h07, 4);
    rd_chk(0, 64'h0, "R6 ctr0 frozen");
    rd_chk(1, 64'h0, "R6 ctr1 frozen");
    rd_chk(2, 64'h4, "R6 ctr2 unselected counts");
    wr(0, 64'h7);
    rd_chk(0, 64'h7, "R12 write while frozen");
    rd_chk(8, 64'h0000_0000_0003_0000, "R10 select readback");
  endtask

  task automatic t_unfreeze;
    wr(8, 64'h0000_0000_0001_0002);
    pulse(8'h03, 2);
    rd_chk(0, 64'h9, "R7 ctr0 resumed");
    rd_chk(1, 64'h0, "R7 ctr1 still frozen");
  endtask

  task automatic t_clr;
    wr(6, 64'h0000_00C3_0000_0037);
    wr(7, 64'h0000_0000_FFFF_FFFF);
    pulse(8'h80, 1);
    rd_chk(8, 64'h0080_0000_0001_0000, "R4 status bit 55");
    pulse(8'h40, 2);
    rd_chk(6, 64'h0000_00C3_0000_0039, "R3 ctr6 counted");
    wr(8, 64'h0000_0000_00C0_0004);
    rd_chk(6, 64'h0000_00C3_0000_0000, "R8 count cleared control kept");
    rd_chk(7, 64'h0, "R8 ctr7 cleared");
    rd_chk(8, 64'h0000_0000_00C0_0000, "R8 status cleared");
    rd_chk(2, 64'h4, "R8 unselected untouched");
  endtask

  task automatic t_both;
    wr(8, 64'h0000_0000_0008_0007);
    pulse(8'h08, 3);
    rd_chk(3, 64'h0000_5A5A_0000_0000, "R9 freeze wins and clear applied");
    wr(8, 64'h0000_0000_0008_0002);
    pulse(8'h08, 2);
    rd_chk(3, 64'h0000_5A5A_0000_0002, "R9 resumed after unfreeze");
  endtask

  task automatic t_glb;
    wr(8, 64'h00FF_0000_00A5_0000);
    rd_chk(8, 64'h0000_0000_00A5_0000, "R10 status not writable");
    wr(8, 64'h0000_0000_0000_0001);
    rd_chk(8, 64'h0, "R10 command reads zero");
    pulse(8'h01, 1);
    rd_chk(0, 64'd10, "R10 empty mask no freeze");
  endtask

  task automatic t_bad;
    wr(9, 64'hDEAD_BEEF_DEAD_BEEF);
    rd_chk(9, 64'h0, "R13 unmapped read zero");
    rd_chk(15, 64'h0, "R13 top address zero");
    rd_chk(0, 64'd10, "R13 no side effect");
    rd_chk(8, 64'h0, "R13 global unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset; t_rw; t_count; t_wrap; t_sat; t_freeze;
    t_unfreeze; t_clr; t_both; t_glb; t_bad;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule